// File: doc/BRIEF.md
# Sprite Vertical Shrink Line Mapper

This block decides which tile of a sprite's column and which row inside that tile feed the current scanline once the sprite is vertically shrunk. It subtracts the sprite's Y position from the scanline to find the line within the sprite. From that line and the sprite's 8-bit shrink value it forms an address into a shrink table held in an external synchronous ROM. The byte that comes back packs two nibbles. The upper nibble selects a tilemap entry and the lower nibble selects a row inside that tile.

A full-height sprite covers 512 lines, and the table only describes the upper 256. For the lower 256 lines the block reads the same sub-table backwards. It then mirrors both fields, so the tile index lands in 16..31 and the row is flipped. A table byte of 0xFF pins the output to the last row of tile 15. Several lines of a shrunk sprite can therefore repeat that row. A one-cycle `start_i` pulse launches one lookup, and the result appears together with `valid_o` one cycle later.

Top module: `vshrink_line_map`

## Requirements
- R1: While `start_i` is high, `rom_addr_o[15:8]` equals `shrink_i`. For example, shrink 0x1B with sprite line 1 gives address 0x1B01.
- R2: The sprite line is `(scanline_i - spr_y_i) mod 512`. Bit 8 of the line high means the lower half.
- R3: In the upper half, `rom_addr_o[7:0]` equals bits 7:0 of the sprite line.
- R4: In the lower half, `rom_addr_o[7:0]` equals the bitwise complement of bits 7:0 of the sprite line.
- R5: In the upper half, `tile_idx_o` is `{1'b0, byte[7:4]}` and `tile_row_o` is `byte[3:0]`, where byte is the ROM data for that address.
- R6: In the lower half, `tile_idx_o` is `{1'b0, byte[7:4]} ^ 5'h1F`, which always has bit 4 set, and `tile_row_o` is `byte[3:0] ^ 4'hF`.
- R7: `valid_o` is high in exactly the cycle after each cycle in which `start_i` is high, and low otherwise. Starts may come back to back.
- R8: In a cycle with `start_i` low, `rom_addr_o` keeps the last launched address. While `valid_o` is low, `tile_idx_o` and `tile_row_o` are zero.
- R9: While `rst_n` is low, `valid_o`, `tile_idx_o`, `tile_row_o` and the held address are all zero.
- R10: A ROM byte of 0xFF yields tile 15 row 15 in the upper half and tile 16 row 0 in the lower half. Distinct lines that read 0xFF give identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | Launches one lookup this cycle |
| scanline_i | input | 9 | Current scanline |
| spr_y_i | input | 9 | Sprite vertical position |
| shrink_i | input | 8 | Vertical shrink value, selects the sub-table |
| rom_addr_o | output | 16 | Shrink table ROM address |
| rom_data_i | input | 8 | ROM byte, one cycle after the address |
| tile_idx_o | output | 5 | Tilemap entry index within the sprite column |
| tile_row_o | output | 4 | Row within the selected tile |
| valid_o | output | 1 | Fields are valid this cycle |

## Verification
The assertions assume the ROM returns, one cycle after the block samples an address, a byte that depends only on that address. The field checks compare outputs with `rom_data_i` in the valid cycle on that basis. They also assume `scanline_i` and `spr_y_i` are stable on the clock edge of each start, because the half flag is recomputed from their past values. The bench models the ROM as a registered pure function of the address. It changes inputs only on the falling edge, and it moves the inputs during idle cycles so that any effect on the held address or the outputs would show.

// File: rtl/vshrink_pkg.sv
package vshrink_pkg;
  localparam int LINE_W = 9;
  localparam int ZOOM_W = 8;
  localparam int NIB_W  = 4;
  localparam int IDX_W  = LINE_W - 1;
  localparam int ADDR_W = ZOOM_W + IDX_W;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int TILE_W = NIB_W + 1;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [TILE_W-1:0] tile_t;
  typedef logic [NIB_W-1:0]  nib_t;
endpackage

// File: rtl/vshrink_line_calc.sv
module vshrink_line_calc #(
  parameter int LINE_W = 9,
  localparam int IDX_W = LINE_W - 1
) (
  input  logic [LINE_W-1:0] scanline_i,
  input  logic [LINE_W-1:0] spr_y_i,
  output logic [IDX_W-1:0]  tbl_idx_o,
  output logic              lower_o
);
  logic [LINE_W-1:0] line_w;

  always_comb begin
    line_w    = scanline_i - spr_y_i;
    lower_o   = line_w[LINE_W-1];
    tbl_idx_o = lower_o ? ~line_w[IDX_W-1:0] : line_w[IDX_W-1:0];
  end
endmodule

// File: rtl/vshrink_addr_hold.sv
module vshrink_addr_hold #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_new_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] held_q, held_d;

  always_comb begin
    held_d = held_q;
    if (load_i) held_d = addr_new_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign addr_o = load_i ? addr_new_i : held_q;
endmodule

// File: rtl/vshrink_field_mirror.sv
module vshrink_field_mirror #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W,
  localparam int TILE_W = NIB_W + 1
) (
  input  logic [BYTE_W-1:0] rom_byte_i,
  input  logic              lower_i,
  input  logic              en_i,
  output logic [TILE_W-1:0] tile_o,
  output logic [NIB_W-1:0]  row_o
);
  logic [NIB_W-1:0] hi_m, lo_m;

  for (genvar b = 0; b < NIB_W; b++) begin : g_flip
    assign hi_m[b] = rom_byte_i[NIB_W+b] ^ lower_i;
    assign lo_m[b] = rom_byte_i[b] ^ lower_i;
  end

  always_comb begin
    tile_o = '0;
    row_o  = '0;
    if (en_i) begin
      tile_o = {lower_i, hi_m};
      row_o  = lo_m;
    end
  end
endmodule

// File: rtl/vshrink_line_map.sv
module vshrink_line_map
  import vshrink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LINE_W-1:0] scanline_i,
  input  logic [LINE_W-1:0] spr_y_i,
  input  logic [ZOOM_W-1:0] shrink_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [BYTE_W-1:0] rom_data_i,
  output logic [TILE_W-1:0] tile_idx_o,
  output logic [NIB_W-1:0]  tile_row_o,
  output logic              valid_o
);
  logic [IDX_W-1:0] tbl_idx_w;
  logic             lower_w;
  logic             valid_q, valid_d;
  logic             lower_q, lower_d;

  vshrink_line_calc #(.LINE_W(LINE_W)) u_calc (
    .scanline_i (scanline_i),
    .spr_y_i    (spr_y_i),
    .tbl_idx_o  (tbl_idx_w),
    .lower_o    (lower_w)
  );

  vshrink_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_i),
    .addr_new_i ({shrink_i, tbl_idx_w}),
    .addr_o     (rom_addr_o)
  );

  always_comb begin
    valid_d = start_i;
    lower_d = lower_q;
    if (start_i) lower_d = lower_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      lower_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      lower_q <= lower_d;
    end
  end

  vshrink_field_mirror #(.NIB_W(NIB_W)) u_mirror (
    .rom_byte_i (rom_data_i),
    .lower_i    (lower_q),
    .en_i       (valid_q),
    .tile_o     (tile_idx_o),
    .row_o      (tile_row_o)
  );

  assign valid_o = valid_q;
endmodule

// File: rtl/vshrink_line_map_chk.sv
module vshrink_line_map_chk
  import vshrink_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [LINE_W-1:0] scanline_i,
  input logic [LINE_W-1:0] spr_y_i,
  input logic [ZOOM_W-1:0] shrink_i,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic [BYTE_W-1:0] rom_data_i,
  input logic [TILE_W-1:0] tile_idx_o,
  input logic [NIB_W-1:0]  tile_row_o,
  input logic              valid_o
);
  logic              armed;
  logic [LINE_W-1:0] chk_line;

  assign chk_line = scanline_i - spr_y_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r7_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);

  a_r1_addr_zoom: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> rom_addr_o[ADDR_W-1 -: ZOOM_W] == shrink_i);

  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !start_i) |-> rom_addr_o == $past(rom_addr_o));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (tile_idx_o == '0 && tile_row_o == '0));

  a_r6_half_tag: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> tile_idx_o[TILE_W-1] == $past(chk_line[LINE_W-1]));

  a_r5_top_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !tile_idx_o[TILE_W-1]) |->
      (tile_row_o == rom_data_i[NIB_W-1:0] && tile_idx_o[NIB_W-1:0] == rom_data_i[BYTE_W-1:NIB_W]));

  a_r6_bottom_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && tile_idx_o[TILE_W-1]) |->
      (tile_row_o == ~rom_data_i[NIB_W-1:0] && tile_idx_o[NIB_W-1:0] == ~rom_data_i[BYTE_W-1:NIB_W]));
endmodule

bind vshrink_line_map vshrink_line_map_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .scanline_i (scanline_i),
  .spr_y_i    (spr_y_i),
  .shrink_i   (shrink_i),
  .rom_addr_o (rom_addr_o),
  .rom_data_i (rom_data_i),
  .tile_idx_o (tile_idx_o),
  .tile_row_o (tile_row_o),
  .valid_o    (valid_o)
);

// File: tb/vshrink_line_map_bench.sv
`timescale 1ns/1ps
module vshrink_line_map_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [8:0] scanline_i, spr_y_i;
  logic [7:0] shrink_i;
  logic [15:0] rom_addr_o;
  logic [7:0] rom_data_i;
  logic [4:0] tile_idx_o;
  logic [3:0] tile_row_o;
  logic       valid_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  logic [15:0] last_addr;

  typedef struct {
    int         due;
    logic [4:0] tile;
    logic [3:0] row;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    if (a == 16'h1B1C || a == 16'h1B1D) return 8'hFF;
    return (a[7:0] * 8'd5) ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) rom_data_i <= rom_fn(rom_addr_o);

  vshrink_line_map u_vshrink_line_map (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scanline_i(scanline_i),
    .spr_y_i(spr_y_i), .shrink_i(shrink_i), .rom_addr_o(rom_addr_o),
    .rom_data_i(rom_data_i), .tile_idx_o(tile_idx_o), .tile_row_o(tile_row_o),
    .valid_o(valid_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int sc, input int y, input int z, input string tag);
    logic [8:0]  line;
    logic [7:0]  idx, b;
    logic [15:0] addr;
    exp_t        e;
    @(negedge clk);
    line = 9'(sc - y);
    idx  = line[8] ? ~line[7:0] : line[7:0];
    addr = {8'(z), idx};
    b    = rom_fn(addr);
    e.due  = cyc + 1;
    e.tile = line[8] ? ({1'b0, b[7:4]} ^ 5'h1F) : {1'b0, b[7:4]};
    e.row  = line[8] ? (b[3:0] ^ 4'hF) : b[3:0];
    e.tag  = tag;
    start_i    = 1'b1;
    scanline_i = 9'(sc);
    spr_y_i    = 9'(y);
    shrink_i   = 8'(z);
    sb.push_back(e);
    last_addr = addr;
    #1;
    check(rom_addr_o == addr, {tag, " R1 R3 R4 address"}, rom_addr_o, addr);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i    = 1'b0;
      scanline_i = 9'(i * 53 + 7);
      spr_y_i    = 9'(i * 29);
      shrink_i   = 8'(i * 71 + 3);
      #1;
      check(rom_addr_o == last_addr, "R8 address held", rom_addr_o, last_addr);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (valid_o) begin
          if (sb.size() == 0) begin
            check(1'b0, "R7 valid with nothing launched", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.due == cyc, {e.tag, " R7 valid timing"}, cyc, e.due);
            check(tile_idx_o == e.tile, {e.tag, " tile"}, tile_idx_o, e.tile);
            check(tile_row_o == e.row, {e.tag, " row"}, tile_row_o, e.row);
          end
        end else begin
          if (sb.size() != 0 && sb[0].due == cyc)
            check(1'b0, {sb[0].tag, " R7 valid missing"}, 0, 1);
          if (tile_idx_o != 0 || tile_row_o != 0)
            check(1'b0, "R8 fields nonzero while idle", {tile_idx_o, tile_row_o}, 0);
        end
      end
    end
  end

  initial begin
    #200000;
    check(1'b0, "watchdog expired", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    scanline_i = '0; spr_y_i = '0; shrink_i = '0;
    last_addr = '0;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R9 reset valid", valid_o, 0);
    check(tile_idx_o == 0 && tile_row_o == 0, "R9 reset fields", {tile_idx_o, tile_row_o}, 0);
    check(rom_addr_o == 16'h0, "R9 reset address", rom_addr_o, 0);
    @(negedge clk) rst_n = 1'b1;

    issue(10, 9, 8'h1B, "R1 R3 R5 line1");
    idle(2);
    issue(28 + 40, 40, 8'h1B, "R10 line28 top 0xFF");
    issue(29 + 40, 40, 8'h1B, "R10 line29 repeats");
    idle(1);
    issue(300, 0, 8'h40, "R4 R6 lower half");
    issue(5, 10, 8'h22, "R2 wrap lower half");
    issue(483, 0, 8'h1B, "R10 lower 0xFF");
    issue(255, 0, 8'h77, "R3 edge 255");
    issue(256, 0, 8'h77, "R4 edge 256");
    idle(3);
    for (int i = 0; i < 24; i++) begin
      issue((i * 37) % 512, (i * 91) % 512, (i * 13) % 256, "R2 R5 R6 sweep");
      if (i % 5 == 4) idle(2);
    end
    idle(4);
    check(sb.size() == 0, "R7 all results seen", sb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule